// File: doc/BRIEF.md
# Display Raster Timing Generator

This block drives the timing side of a parallel LCD or monitor link. On every pixel clock it advances a horizontal and a vertical position counter and decodes them into a horizontal sync, a vertical sync, a data-enable strobe and a 24-bit RGB value. Software sets the active size, porches, pulse widths, sync polarity, background colour, eight test-bar colours and an operating mode through a simple write-only register port.

In normal mode, every active pixel carries the background colour. Plane data is merged downstream, outside this block. In colour-bar mode the active width is split into eight equal vertical bars, and each bar takes its colour from its own register. A running raster picks up a new configuration only at the frame boundary. While the block is off, writes are applied almost at once, so the first frame after switching on is built from the values just written.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the mode is off. Both syncs are low, `de_o` is low, `rgb_o` is zero and both position outputs are zero.
- R2: A line runs sync pulse, back porch, active, front porch, and its length is the sum of the four. The horizontal word at address 2 packs the back porch in [31:22], the pulse in [21:11] and the front porch in [10:0]. The active width is the low 16 bits of the size word at address 1. `h_pos_o` counts from 0 and wraps at the end of the line.
- R3: A frame runs pulse, back porch, active, front porch, counted in lines. The vertical word at address 3 uses the same field layout, and the active height is size[31:16]. `v_pos_o` advances only when the line wraps.
- R4: `de_o` is high only on pixels that are active both horizontally and vertically. `rgb_o` is zero whenever `de_o` is low.
- R5: The mode is the code in data[2:0] at address 0. Code 1 is normal display, where every active pixel shows background colour data[23:0] from address 5. Code 4 is colour bars. Codes 0, 2, 3 and 5 to 7 are off. While off, both positions stay at zero, `de_o` is low and the syncs sit at their inactive level.
- R6: In colour-bar mode, active pixel x shows bar floor(x*8/width). Bar i takes its colour from data[23:0] written to address 8+i, with red in [23:16].
- R7: Bit 0 of the word at address 4 inverts the horizontal sync and bit 1 inverts the vertical sync. With 0, both pulses are active high.
- R8: While running, a configuration write takes effect in the first cycle of the next frame. While off, a write takes effect two clock edges after it is presented.
- R9: The 800x480 timing runs with a line of 1056 pixels and a frame of 525 lines. The horizontal porches and pulse are 86/128/42 and the vertical ones are 33/2/10.
- R10: Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| rgb_o | output | 24 | Pixel colour, 8:8:8 |
| h_pos_o | output | 17 | Pixel position within the line |
| v_pos_o | output | 17 | Line position within the frame |

## Verification
The assertions assume that software programs a usable raster. That means a horizontal blanking of at least one pixel, a non-zero active height, and in bar mode an active width of at least eight pixels. A porch-free line would make the bar tracker run straight into the next line, and a zero total would leave the counters with no wrap point. Every timing the stimulus writes meets these limits. Configuration changes in the stimulus are made either while the block is off or at arbitrary points of a running frame, so that the frame-boundary hand-over is exercised both ways.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int BP_W     = 10;
  localparam int PW_W     = 11;
  localparam int FP_W     = 11;
  localparam int ACT_W    = 16;
  localparam int POS_W    = ACT_W + 1;
  localparam int RGB_W    = 24;
  localparam int NUM_BARS = 8;
  localparam int BAR_IW   = $clog2(NUM_BARS);
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int MODE_W   = 3;

  localparam logic [MODE_W-1:0] MODE_NORM = 3'd1;
  localparam logic [MODE_W-1:0] MODE_BARS = 3'd4;

  localparam logic [ADDR_W-1:0] A_MODE  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SIZE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_HTIM  = 4'd2;
  localparam logic [ADDR_W-1:0] A_VTIM  = 4'd3;
  localparam logic [ADDR_W-1:0] A_POL   = 4'd4;
  localparam logic [ADDR_W-1:0] A_BG    = 4'd5;
  localparam logic [ADDR_W-1:0] A_BAR0  = 4'd8;

  typedef struct packed {
    logic [PW_W-1:0]  pw;
    logic [BP_W-1:0]  bp;
    logic [FP_W-1:0]  fp;
    logic [ACT_W-1:0] act;
  } axis_cfg_t;

  typedef struct packed {
    logic [MODE_W-1:0]                  mode;
    axis_cfg_t                          h;
    axis_cfg_t                          v;
    logic                               pol_h;
    logic                               pol_v;
    logic [RGB_W-1:0]                   bg;
    logic [NUM_BARS-1:0][RGB_W-1:0]     bars;
  } raster_cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  output raster_cfg_t       cfg_o,
  output logic              run_o
);
  raster_cfg_t live_q, live_d, shad_q;
  logic [ADDR_W-1:0] bar_off;

  assign bar_off = addr_i - A_BAR0;

  always_comb begin
    live_d = live_q;
    if (we_i) begin
      unique case (addr_i)
        A_MODE: live_d.mode = wdata_i[MODE_W-1:0];
        A_SIZE: begin
          live_d.v.act = wdata_i[31:16];
          live_d.h.act = wdata_i[15:0];
        end
        A_HTIM: begin
          live_d.h.bp = wdata_i[31:22];
          live_d.h.pw = wdata_i[21:11];
          live_d.h.fp = wdata_i[10:0];
        end
        A_VTIM: begin
          live_d.v.bp = wdata_i[31:22];
          live_d.v.pw = wdata_i[21:11];
          live_d.v.fp = wdata_i[10:0];
        end
        A_POL: begin
          live_d.pol_h = wdata_i[0];
          live_d.pol_v = wdata_i[1];
        end
        A_BG: live_d.bg = wdata_i[RGB_W-1:0];
        default: begin
          if (addr_i >= A_BAR0 && bar_off < ADDR_W'(NUM_BARS))
            live_d.bars[bar_off[BAR_IW-1:0]] = wdata_i[RGB_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      shad_q <= '0;
    end else begin
      live_q <= live_d;
      if (load_i) shad_q <= live_q;
    end
  end

  assign cfg_o = shad_q;
  assign run_o = (shad_q.mode == MODE_NORM) || (shad_q.mode == MODE_BARS);
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  axis_cfg_t        cfg_i,
  output logic [POS_W-1:0] pos_o,
  output logic             pulse_o,
  output logic             active_o,
  output logic             last_o
);
  logic [POS_W-1:0] pos_q, act_lo, act_hi, last_pos;

  // order within the period: pulse, back porch, active, front porch
  assign act_lo   = POS_W'(cfg_i.pw) + POS_W'(cfg_i.bp);
  assign act_hi   = act_lo + POS_W'(cfg_i.act);
  assign last_pos = act_hi + POS_W'(cfg_i.fp) - POS_W'(1);

  assign last_o   = (pos_q == last_pos);
  assign pulse_o  = (pos_q < POS_W'(cfg_i.pw));
  assign active_o = (pos_q >= act_lo) && (pos_q < act_hi);
  assign pos_o    = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (clr_i)  pos_q <= '0;
    else if (step_i) pos_q <= last_o ? '0 : pos_q + POS_W'(1);
  end
endmodule

// File: rtl/rtg_pix.sv
module rtg_pix
  import rtg_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           de_i,
  input  logic                           bars_i,
  input  logic [ACT_W-1:0]               width_i,
  input  logic [RGB_W-1:0]               bg_i,
  input  logic [NUM_BARS-1:0][RGB_W-1:0] palette_i,
  output logic [RGB_W-1:0]               rgb_o
);
  logic [ACT_W-1:0]  acc_q;
  logic [BAR_IW-1:0] bar_q;
  logic [ACT_W:0]    acc_sum;

  // acc tracks (x*NUM_BARS) mod width, bar_q the quotient
  assign acc_sum = {1'b0, acc_q} + (ACT_W+1)'(NUM_BARS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      bar_q <= '0;
    end else if (!de_i) begin
      acc_q <= '0;
      bar_q <= '0;
    end else if (acc_sum >= {1'b0, width_i}) begin
      acc_q <= ACT_W'(acc_sum - {1'b0, width_i});
      bar_q <= bar_q + BAR_IW'(1);
    end else begin
      acc_q <= acc_sum[ACT_W-1:0];
    end
  end

  always_comb begin
    if (!de_i)       rgb_o = '0;
    else if (bars_i) rgb_o = palette_i[bar_q];
    else             rgb_o = bg_i;
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [RGB_W-1:0]  rgb_o,
  output logic [POS_W-1:0]  h_pos_o,
  output logic [POS_W-1:0]  v_pos_o
);
  raster_cfg_t cfg;
  logic run, frame_end, load;
  logic h_pulse, h_act, h_last, v_pulse, v_act, v_last;

  assign frame_end = run & h_last & v_last;
  assign load      = ~run | frame_end;

  rtg_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .load_i(load), .cfg_o(cfg), .run_o(run)
  );

  rtg_axis u_hax (
    .clk_i, .rst_ni, .clr_i(~run), .step_i(run), .cfg_i(cfg.h),
    .pos_o(h_pos_o), .pulse_o(h_pulse), .active_o(h_act), .last_o(h_last)
  );

  rtg_axis u_vax (
    .clk_i, .rst_ni, .clr_i(~run), .step_i(run & h_last), .cfg_i(cfg.v),
    .pos_o(v_pos_o), .pulse_o(v_pulse), .active_o(v_act), .last_o(v_last)
  );

  assign de_o    = run & h_act & v_act;
  assign hsync_o = (run & h_pulse) ^ cfg.pol_h;
  assign vsync_o = (run & v_pulse) ^ cfg.pol_v;

  rtg_pix u_pix (
    .clk_i, .rst_ni, .de_i(de_o), .bars_i(cfg.mode == MODE_BARS),
    .width_i(cfg.h.act), .bg_i(cfg.bg), .palette_i(cfg.bars), .rgb_o(rgb_o)
  );
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk
  import rtg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             frame_end_i,
  input raster_cfg_t      cfg_i,
  input logic             de_i,
  input logic [RGB_W-1:0] rgb_i,
  input logic [POS_W-1:0] h_pos_i,
  input logic [POS_W-1:0] v_pos_i
);
  a_r4_blank_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |-> rgb_i == '0);

  a_r2_hpos_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_pos_i != '0) |-> h_pos_i == $past(h_pos_i) + POS_W'(1));

  a_r3_vpos_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_pos_i != $past(v_pos_i)) |-> h_pos_i == '0);

  a_r5_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (h_pos_i == '0 && v_pos_i == '0 && !de_i));

  a_r8_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !frame_end_i) |=> $stable(cfg_i));
endmodule

bind raster_timing_gen raster_timing_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .frame_end_i(frame_end),
  .cfg_i(cfg), .de_i(de_o), .rgb_i(rgb_o), .h_pos_i(h_pos_o), .v_pos_i(v_pos_o)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        hsync_o, vsync_o, de_o;
  logic [23:0] rgb_o;
  logic [16:0] h_pos_o, v_pos_o;

  always #10 clk_i = ~clk_i;

  raster_timing_gen u0 (.*);

  typedef struct {
    int mode, hpw, hbp, hfp, hact, vpw, vbp, vfp, vact;
    bit polh, polv;
    int bg;
    int bar[8];
  } mcfg_t;

  mcfg_t cur, live;
  int m_h, m_v;
  int n_chk = 0, n_bad = 0;
  int e_cnt[4];
  longint e_act[4], e_exp[4];

  task automatic check(string req, bit ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic mcfg_t apply(mcfg_t c, int a, logic [31:0] d);
    mcfg_t r = c;
    case (a)
      0: r.mode = int'(d[2:0]);
      1: begin r.vact = int'(d[31:16]); r.hact = int'(d[15:0]); end
      2: begin r.hbp = int'(d[31:22]); r.hpw = int'(d[21:11]); r.hfp = int'(d[10:0]); end
      3: begin r.vbp = int'(d[31:22]); r.vpw = int'(d[21:11]); r.vfp = int'(d[10:0]); end
      4: begin r.polh = d[0]; r.polv = d[1]; end
      5: r.bg = int'(d[23:0]);
      default: if (a >= 8 && a < 16) r.bar[a-8] = int'(d[23:0]);
    endcase
    return r;
  endfunction

  task automatic note(int k, longint act, longint exp);
    if (e_cnt[k] == 0) begin e_act[k] = act; e_exp[k] = exp; end
    e_cnt[k]++;
  endtask

  // compare at the current negedge, advance the model through the next edge
  task automatic step();
    bit run, hs, vs, de, hl, vl;
    int x, rgb;
    run = (cur.mode == 1) || (cur.mode == 4);
    hs = (run && m_h < cur.hpw) ^ cur.polh;
    vs = (run && m_v < cur.vpw) ^ cur.polv;
    de = run && m_h >= cur.hpw + cur.hbp && m_h < cur.hpw + cur.hbp + cur.hact
             && m_v >= cur.vpw + cur.vbp && m_v < cur.vpw + cur.vbp + cur.vact;
    x = m_h - cur.hpw - cur.hbp;
    rgb = !de ? 0 : (cur.mode == 4) ? cur.bar[(x * 8) / cur.hact] : cur.bg;
    if (hsync_o !== hs || int'(h_pos_o) != m_h) note(0, {hsync_o, 15'd0, h_pos_o}, {hs, 15'd0, 17'(m_h)});
    if (vsync_o !== vs || int'(v_pos_o) != m_v) note(1, {vsync_o, 15'd0, v_pos_o}, {vs, 15'd0, 17'(m_v)});
    if (de_o !== de) note(2, de_o, de);
    if (int'(rgb_o) != rgb) note(3, rgb_o, rgb);
    hl = m_h == cur.hpw + cur.hbp + cur.hact + cur.hfp - 1;
    vl = m_v == cur.vpw + cur.vbp + cur.vact + cur.vfp - 1;
    if (run) begin
      if (hl) begin m_h = 0; m_v = vl ? 0 : m_v + 1; end
      else m_h++;
    end else begin
      m_h = 0; m_v = 0;
    end
    if (!run || (hl && vl)) cur = live;
    if (reg_we_i) live = apply(live, int'(reg_addr_i), reg_wdata_i);
    @(negedge clk_i);
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_addr_i = 4'(a); reg_wdata_i = d; reg_we_i = 1'b1;
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic run_n(int n);
    repeat (n) step();
  endtask

  task automatic open_s();
    for (int k = 0; k < 4; k++) e_cnt[k] = 0;
  endtask

  task automatic close_s(string th, string tv, string td, string tr);
    check(th, e_cnt[0] == 0, e_act[0], e_exp[0]);
    check(tv, e_cnt[1] == 0, e_act[1], e_exp[1]);
    check(td, e_cnt[2] == 0, e_act[2], e_exp[2]);
    check(tr, e_cnt[3] == 0, e_act[3], e_exp[3]);
  endtask

  localparam logic [31:0] HT = (32'd3 << 22) | (32'd2 << 11) | 32'd1;
  localparam logic [31:0] VT = (32'd2 << 22) | (32'd1 << 11) | 32'd1;

  task automatic t_reset();
    check("R1 hsync", hsync_o == 1'b0, hsync_o, 0);
    check("R1 vsync", vsync_o == 1'b0, vsync_o, 0);
    check("R1 de", de_o == 1'b0, de_o, 0);
    check("R1 rgb", rgb_o == '0, rgb_o, 0);
    check("R1 pos", h_pos_o == '0 && v_pos_o == '0, {h_pos_o, v_pos_o}, 0);
  endtask

  task automatic t_normal();
    open_s();
    wr(1, (32'd4 << 16) | 32'd16);
    wr(2, HT);
    wr(3, VT);
    wr(5, 32'hAA7F7F7F);
    wr(0, 32'd1);
    run_n(2 * 176 + 5);
    close_s("R2", "R3", "R4", "R5 background");
  endtask

  task automatic t_bars();
    open_s();
    for (int i = 0; i < 8; i++) wr(8 + i, 32'hFF000000 | (32'(i + 1) * 32'h00112233));
    wr(0, 32'd4);
    run_n(40);
    close_s("R8 hold", "R8 hold", "R8 hold", "R8 pending mode");
    open_s();
    run_n(2 * 176);
    close_s("R2 bars", "R3 bars", "R4 bars", "R6");
  endtask

  task automatic t_pol();
    open_s();
    wr(4, 32'd3);
    run_n(2 * 176);
    close_s("R7 hsync", "R7 vsync", "R4", "R6");
  endtask

  task automatic t_ignored();
    open_s();
    wr(6, 32'hFFFFFFFF);
    wr(7, 32'h12345678);
    run_n(2 * 176);
    close_s("R10", "R10", "R10", "R10");
  endtask

  task automatic t_off();
    open_s();
    wr(0, 32'd2);
    run_n(200);
    check("R5 off pos", h_pos_o == '0 && v_pos_o == '0, {h_pos_o, v_pos_o}, 0);
    check("R5 off de", de_o == 1'b0, de_o, 0);
    wr(0, 32'd3);
    run_n(30);
    wr(0, 32'd7);
    run_n(30);
    wr(4, 32'd0);
    run_n(5);
    close_s("R5 off", "R5 off", "R5 off", "R5 off");
  endtask

  task automatic t_800();
    open_s();
    wr(1, (32'd480 << 16) | 32'd800);
    wr(2, (32'd86 << 22) | (32'd128 << 11) | 32'd42);
    wr(3, (32'd33 << 22) | (32'd2 << 11) | 32'd10);
    wr(5, 32'h007F7F7F);
    wr(0, 32'd1);
    run_n(38 * 1056);
    close_s("R9 line", "R9 frame", "R9 de", "R9 rgb");
  endtask

  initial begin
    cur = '{default: 0, bar: '{default: 0}};
    live = cur;
    m_h = 0; m_v = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_normal();
    t_bars();
    t_pol();
    t_ignored();
    t_off();
    t_800();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule